// File: doc/BRIEF.md
# Segment Translation and Protection Checker

This block keeps four cached segment entries, one each for the code, stack, data and extra segments, and turns a segment-index/offset pair into a physical address in the same cycle. A load port fills an entry from a selector and an eight-byte descriptor. An access port presents a segment index, a 16-bit offset, a byte or word width and an access kind. The block answers at once with the address, a fault flag and an exception number.

A mode input selects between two translation schemes. In real mode the selector scaled by sixteen is added to the offset, the sum wraps within 20 bits, and only one check is made: a word access must not straddle the end of the segment. In protected mode the cached 24-bit base is added to the offset, the result wraps within 24 bits, and the access must pass the limit rules for its segment direction and the rights encoded in the access byte. Loading descriptors from memory tables and comparing privilege levels are left to the surrounding logic.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset every entry holds selector 0 and access byte 00h, and no entry is usable in protected mode.
- R2: In real mode (`prot_mode`=0) `acc_addr` is (selector·16 + offset) mod 2^20, zero-extended to 24 bits.
- R3: In real mode there are no limit or rights checks; the only fault is a word access at offset FFFFh, which reports exception 13.
- R4: A real-mode load never faults and stores the selector, base = selector·16, limit FFFFh and access byte 9Bh for segment index 0 (code) or 93h for indices 1–3 (stack, data, extra); the descriptor bytes are ignored.
- R5: In protected mode `acc_addr` is (cached base + offset) mod 2^24.
- R6: For an expand-up segment (access byte bit 3 = 1, or bit 3 = 0 with bit 2 = 0), every byte touched (offset, and offset+1 for a word) must be at most the limit, else exception 13.
- R7: For an expand-down data segment (bit 3 = 0, bit 2 = 1), every byte touched must be above the limit and at most FFFFh, else exception 13.
- R8: Access kinds are 0 read, 1 write, 2 fetch (3 behaves as read). A write to code (bit 3 = 1), a write to data with bit 1 = 0, a read of code with bit 1 = 0, and a fetch from data all fault with exception 13.
- R9: A protected-mode load whose access byte has bit 4 (system/segment) = 0 faults with 13; otherwise one with bit 7 (present) = 0 faults with 11; a faulting load leaves the cache unchanged.
- R10: A successful protected-mode load stores the base (descriptor bytes 2–4), limit (bytes 0–1) and access byte (byte 5) with bit 0 forced to 1; `acc_rights` shows the stored access byte of the addressed entry.
- R11: A protected-mode access to an entry that has never been loaded faults with exception 13.
- R12: With `acc_valid` low, `acc_fault` is 0 and `acc_exc` is 0; with `ld_valid` low, `ld_fault` and `ld_exc` are 0; an exception output is 0 whenever its fault flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_mode | input | 1 | 1 selects protected translation, 0 real mode |
| ld_valid | input | 1 | Load request this cycle |
| ld_seg | input | 2 | Entry to load: 0 code, 1 stack, 2 data, 3 extra |
| ld_sel | input | 16 | Selector to cache |
| ld_desc | input | 64 | Descriptor: limit bytes 0–1, base bytes 2–4, access byte 5 |
| ld_fault | output | 1 | Load rejected |
| ld_exc | output | 8 | Exception number of a rejected load, else 0 |
| acc_valid | input | 1 | Access request this cycle |
| acc_seg | input | 2 | Entry used by the access |
| acc_off | input | 16 | Offset within the segment |
| acc_word | input | 1 | 1 word, 0 byte |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_fault | output | 1 | Access violation |
| acc_exc | output | 8 | Exception number of a violation, else 0 |
| acc_addr | output | 24 | Physical address (meaningless when faulting) |
| acc_rights | output | 8 | Stored access byte of the addressed entry |

## Verification
The bench aims at the last byte of each segment: a word whose second byte crosses an expand-up limit, an expand-down offset equal to the limit, and a word at FFFFh in both modes; a design checking only the first byte, or using the wrong inequality, accepts these. It forces address wraparound in both modes, so a design carrying the 21st or 25th bit reports a wrong address. It loads descriptors that are non-present, system-type, and both at once, then reads the same entry back; a design with the wrong fault priority or that writes the cache on a rejected load shows the wrong exception or altered rights and base. Execute-only code, read-only data and fetches from data each get a separate access.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_N  = 4;
  localparam int SEG_IW = $clog2(SEG_N);
  localparam int OFF_W  = 16;
  localparam int SEL_W  = 16;
  localparam int BASE_W = 24;
  localparam int REAL_W = SEL_W + 4;
  localparam int AR_W   = 8;
  localparam int EXC_W  = 8;
  localparam int DESC_W = 64;

  localparam logic [EXC_W-1:0] EXC_NONE = '0;
  localparam logic [EXC_W-1:0] EXC_NP   = 8'd11;
  localparam logic [EXC_W-1:0] EXC_GP   = 8'd13;

  // access byte bit positions
  localparam int AR_P   = 7;
  localparam int AR_S   = 4;
  localparam int AR_E   = 3;
  localparam int AR_EDC = 2;
  localparam int AR_RW  = 1;
  localparam int AR_A   = 0;

  localparam logic [AR_W-1:0] AR_REAL_CODE = 8'h9B;
  localparam logic [AR_W-1:0] AR_REAL_DATA = 8'h93;
  localparam logic [SEG_IW-1:0] SEG_CODE   = '0;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic              vld;
    logic [SEL_W-1:0]  sel;
    logic [BASE_W-1:0] base;
    logic [OFF_W-1:0]  lim;
    logic [AR_W-1:0]   ar;
  } seg_ent_t;

  function automatic logic [BASE_W-1:0] f_real_base(input logic [SEL_W-1:0] sel);
    logic [REAL_W-1:0] sh;
    sh = {sel, 4'h0};
    return BASE_W'(sh);
  endfunction

  function automatic logic [BASE_W-1:0] f_real_addr(input logic [SEL_W-1:0] sel,
                                                    input logic [OFF_W-1:0] off);
    logic [REAL_W-1:0] sum;
    sum = {sel, 4'h0} + REAL_W'(off);
    return BASE_W'(sum);
  endfunction

  function automatic logic [BASE_W-1:0] f_prot_addr(input logic [BASE_W-1:0] base,
                                                    input logic [OFF_W-1:0] off);
    return base + BASE_W'(off);
  endfunction

  // both bytes of a word are checked; hi is the last byte touched
  function automatic logic f_limit_ok(input logic [OFF_W-1:0] lim,
                                      input logic [OFF_W-1:0] off,
                                      input logic             word,
                                      input logic             expdn);
    logic [OFF_W:0] hi;
    hi = {1'b0, off} + (OFF_W+1)'(word);
    if (expdn) return (off > lim) && !hi[OFF_W];
    else       return hi <= {1'b0, lim};
  endfunction

  function automatic logic f_rights_ok(input logic [AR_W-1:0] ar,
                                       input logic [1:0]      kind);
    logic code;
    code = ar[AR_E];
    case (kind)
      ACC_WR:  return !code && ar[AR_RW];
      ACC_EX:  return code;
      default: return !code || ar[AR_RW];
    endcase
  endfunction
endpackage

// File: rtl/seg_load_check.sv
module seg_load_check
  import seg_pkg::*;
(
  input  logic              prot_mode,
  input  logic              ld_valid,
  input  logic [SEG_IW-1:0] ld_seg,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DESC_W-1:0] ld_desc,
  output logic              ld_reject,
  output logic [EXC_W-1:0]  ld_exc,
  output logic              wr_en,
  output seg_ent_t          wr_ent
);
  logic [AR_W-1:0] ar_in;
  logic            sys_bad;
  logic            np_bad;
  logic            desc_hi_unused;

  assign ar_in          = ld_desc[47:40];
  assign desc_hi_unused = ^ld_desc[DESC_W-1:48];
  assign sys_bad        = !ar_in[AR_S];
  assign np_bad         = !ar_in[AR_P];
  assign ld_reject      = ld_valid && prot_mode && (sys_bad || np_bad);
  assign wr_en          = ld_valid && !ld_reject;

  always_comb begin
    if (!ld_reject)   ld_exc = EXC_NONE;
    else if (sys_bad) ld_exc = EXC_GP;
    else              ld_exc = EXC_NP;
  end

  always_comb begin
    wr_ent.vld = 1'b1;
    wr_ent.sel = ld_sel;
    if (prot_mode) begin
      wr_ent.base = ld_desc[39:16];
      wr_ent.lim  = ld_desc[15:0];
      wr_ent.ar   = ar_in | AR_W'(1 << AR_A);
    end else begin
      wr_ent.base = f_real_base(ld_sel);
      wr_ent.lim  = '1;
      wr_ent.ar   = (ld_seg == SEG_CODE) ? AR_REAL_CODE : AR_REAL_DATA;
    end
  end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_pkg::*;
#(
  parameter int NUM_SEG = SEG_N,
  localparam int IDX_W  = $clog2(NUM_SEG)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  seg_ent_t                wr_ent,
  input  logic [IDX_W-1:0]        rd_idx,
  output seg_ent_t                rd_ent,
  output seg_ent_t [NUM_SEG-1:0]  ents_o
);
  seg_ent_t ent_q [NUM_SEG];

  for (genvar gi = 0; gi < NUM_SEG; gi++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 ent_q[gi] <= '0;
      else if (wr_en && wr_idx == IDX_W'(gi))     ent_q[gi] <= wr_ent;
    end
    assign ents_o[gi] = ent_q[gi];
  end

  assign rd_ent = ent_q[rd_idx];
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_pkg::*;
(
  input  logic              prot_mode,
  input  logic              acc_valid,
  input  logic [OFF_W-1:0]  acc_off,
  input  logic              acc_word,
  input  logic [1:0]        acc_kind,
  input  seg_ent_t          ent,
  output logic              lim_bad,
  output logic              rights_bad,
  output logic              real_wrap,
  output logic              acc_fault,
  output logic [EXC_W-1:0]  acc_exc,
  output logic [BASE_W-1:0] acc_addr
);
  logic miss;
  logic prot_bad;

  assign real_wrap  = acc_word && (acc_off == '1);
  assign miss       = !ent.vld;
  assign lim_bad    = !f_limit_ok(ent.lim, acc_off, acc_word,
                                  !ent.ar[AR_E] && ent.ar[AR_EDC]);
  assign rights_bad = !f_rights_ok(ent.ar, acc_kind);
  assign prot_bad   = miss || lim_bad || rights_bad;

  assign acc_fault = acc_valid && (prot_mode ? prot_bad : real_wrap);
  assign acc_exc   = acc_fault ? EXC_GP : EXC_NONE;
  assign acc_addr  = prot_mode ? f_prot_addr(ent.base, acc_off)
                               : f_real_addr(ent.sel, acc_off);
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prot_mode,
  input  logic               ld_valid,
  input  logic [1:0]         ld_seg,
  input  logic [15:0]        ld_sel,
  input  logic [63:0]        ld_desc,
  output logic               ld_fault,
  output logic [7:0]         ld_exc,
  input  logic               acc_valid,
  input  logic [1:0]         acc_seg,
  input  logic [15:0]        acc_off,
  input  logic               acc_word,
  input  logic [1:0]         acc_kind,
  output logic               acc_fault,
  output logic [7:0]         acc_exc,
  output logic [23:0]        acc_addr,
  output logic [7:0]         acc_rights
);
  logic                   cache_we;
  seg_ent_t               cache_wdata;
  seg_ent_t               cache_rdata;
  seg_ent_t [SEG_N-1:0]   ent_all;
  logic                   lim_bad_w;
  logic                   rights_bad_w;
  logic                   real_wrap_w;

  seg_load_check u_load (
    .prot_mode (prot_mode),
    .ld_valid  (ld_valid),
    .ld_seg    (ld_seg),
    .ld_sel    (ld_sel),
    .ld_desc   (ld_desc),
    .ld_reject (ld_fault),
    .ld_exc    (ld_exc),
    .wr_en     (cache_we),
    .wr_ent    (cache_wdata)
  );

  seg_desc_cache #(.NUM_SEG(SEG_N)) u_cache (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cache_we),
    .wr_idx (ld_seg),
    .wr_ent (cache_wdata),
    .rd_idx (acc_seg),
    .rd_ent (cache_rdata),
    .ents_o (ent_all)
  );

  seg_access_check u_acc (
    .prot_mode  (prot_mode),
    .acc_valid  (acc_valid),
    .acc_off    (acc_off),
    .acc_word   (acc_word),
    .acc_kind   (acc_kind),
    .ent        (cache_rdata),
    .lim_bad    (lim_bad_w),
    .rights_bad (rights_bad_w),
    .real_wrap  (real_wrap_w),
    .acc_fault  (acc_fault),
    .acc_exc    (acc_exc),
    .acc_addr   (acc_addr)
  );

  assign acc_rights = cache_rdata.ar;
endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva
  import seg_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 prot_mode,
  input logic                 ld_valid,
  input logic [1:0]           ld_seg,
  input logic                 ld_fault,
  input logic [7:0]           ld_exc,
  input logic                 acc_valid,
  input logic [15:0]          acc_off,
  input logic                 acc_word,
  input logic [1:0]           acc_kind,
  input logic                 acc_fault,
  input logic [7:0]           acc_exc,
  input logic [7:0]           acc_rights,
  input logic                 real_wrap,
  input seg_ent_t [SEG_N-1:0] ents
);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_fault && acc_exc == EXC_NONE));

  assert_ld_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (!ld_fault && ld_exc == EXC_NONE));

  assert_acc_exc_gp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> acc_exc == EXC_GP);

  assert_real_word_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !prot_mode && acc_word && acc_off == 16'hFFFF) |-> (real_wrap && acc_fault));

  assert_real_no_other_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !prot_mode && !(acc_word && acc_off == 16'hFFFF)) |-> !acc_fault);

  assert_code_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && prot_mode && acc_kind == ACC_WR && acc_rights[AR_E]) |-> acc_fault);

  assert_ld_exc_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> (prot_mode && (ld_exc == EXC_NP || ld_exc == EXC_GP)));

  assert_reject_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_fault) |=> $stable(ents));

  assert_accessed_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_fault && prot_mode) |=> (ents[$past(ld_seg)].ar[AR_A] && ents[$past(ld_seg)].vld));
endmodule

bind seg_xlate_top seg_xlate_sva sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .prot_mode  (prot_mode),
  .ld_valid   (ld_valid),
  .ld_seg     (ld_seg),
  .ld_fault   (ld_fault),
  .ld_exc     (ld_exc),
  .acc_valid  (acc_valid),
  .acc_off    (acc_off),
  .acc_word   (acc_word),
  .acc_kind   (acc_kind),
  .acc_fault  (acc_fault),
  .acc_exc    (acc_exc),
  .acc_rights (acc_rights),
  .real_wrap  (real_wrap_w),
  .ents       (ent_all)
);

// File: tb/seg_xlate_top_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_mode = 1'b0;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic [63:0] ld_desc = '0;
  logic        ld_fault;
  logic [7:0]  ld_exc;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_seg = '0;
  logic [15:0] acc_off = '0;
  logic        acc_word = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic        acc_fault;
  logic [7:0]  acc_exc;
  logic [23:0] acc_addr;
  logic [7:0]  acc_rights;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  seg_xlate_top dut_i (
    .clk(clk), .rst_n(rst_n), .prot_mode(prot_mode),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_desc(ld_desc),
    .ld_fault(ld_fault), .ld_exc(ld_exc),
    .acc_valid(acc_valid), .acc_seg(acc_seg), .acc_off(acc_off),
    .acc_word(acc_word), .acc_kind(acc_kind),
    .acc_fault(acc_fault), .acc_exc(acc_exc), .acc_addr(acc_addr),
    .acc_rights(acc_rights)
  );

  typedef struct {
    string       tag;
    bit          is_ld;
    bit          fault;
    logic [7:0]  exc;
    bit          chk_addr;
    logic [23:0] addr;
    bit          chk_r;
    logic [7:0]  rights;
  } exp_t;

  exp_t sb_q[$];

  function automatic logic [63:0] mkdesc(input logic [23:0] base,
                                         input logic [15:0] lim,
                                         input logic [7:0]  ab);
    return {16'h0000, ab, base, lim};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: loads
  task automatic ld(input string tag, input bit prot, input logic [1:0] seg,
                    input logic [15:0] sel, input logic [63:0] desc,
                    input bit f, input logic [7:0] exc);
    exp_t e;
    @(negedge clk);
    prot_mode = prot; ld_valid = 1'b1; acc_valid = 1'b0;
    ld_seg = seg; ld_sel = sel; ld_desc = desc;
    e.tag = tag; e.is_ld = 1'b1; e.fault = f; e.exc = exc;
    e.chk_addr = 1'b0; e.addr = '0; e.chk_r = 1'b0; e.rights = '0;
    sb_q.push_back(e);
  endtask

  // driver: accesses (a fault always means exception 13)
  task automatic acc(input string tag, input bit prot, input logic [1:0] seg,
                     input logic [15:0] off, input bit word, input logic [1:0] kind,
                     input bit f, input logic [23:0] addr, input logic [7:0] rights);
    exp_t e;
    @(negedge clk);
    prot_mode = prot; ld_valid = 1'b0; acc_valid = 1'b1;
    acc_seg = seg; acc_off = off; acc_word = word; acc_kind = kind;
    e.tag = tag; e.is_ld = 1'b0; e.fault = f; e.exc = f ? 8'd13 : 8'd0;
    e.chk_addr = !f; e.addr = addr; e.chk_r = 1'b1; e.rights = rights;
    sb_q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.is_ld) begin
          check(e.tag, "ld_fault", 32'(ld_fault), 32'(e.fault));
          check(e.tag, "ld_exc",   32'(ld_exc),   32'(e.exc));
        end else begin
          check(e.tag, "acc_fault", 32'(acc_fault), 32'(e.fault));
          check(e.tag, "acc_exc",   32'(acc_exc),   32'(e.exc));
          if (e.chk_addr) check(e.tag, "acc_addr",   32'(acc_addr),   32'(e.addr));
          if (e.chk_r)    check(e.tag, "acc_rights", 32'(acc_rights), 32'(e.rights));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: reset state, real-mode address from selector 0
    acc("R1_R2 reset real", 0, 2'd1, 16'h1234, 0, 2'd0, 0, 24'h001234, 8'h00);
    // R11: protected access to never-loaded entry
    acc("R11 unloaded",     1, 2'd2, 16'h0010, 0, 2'd0, 1, 24'h0, 8'h00);

    // R4: real loads ignore descriptor bytes
    ld ("R4 real ld code", 0, 2'd0, 16'hF000, mkdesc(24'h0, 16'h0, 8'h00), 0, 8'd0);
    acc("R2_R4 real fetch", 0, 2'd0, 16'hFFF0, 0, 2'd2, 0, 24'h0FFFF0, 8'h9B);
    ld ("R4 real ld extra", 0, 2'd3, 16'hFFFF, mkdesc(24'h0, 16'h0, 8'h02), 0, 8'd0);
    acc("R2 real wrap20",   0, 2'd3, 16'h0020, 0, 2'd0, 0, 24'h000010, 8'h93);
    acc("R3 real word end", 0, 2'd3, 16'hFFFF, 1, 2'd0, 1, 24'h0, 8'h93);
    acc("R3 real byte end", 0, 2'd3, 16'hFFFF, 0, 2'd0, 0, 24'h0FFEF, 8'h93);
    acc("R3 real code wr",  0, 2'd0, 16'h0010, 0, 2'd1, 0, 24'h0F0010, 8'h9B);
    acc("R8 prot wr code",  1, 2'd0, 16'h0010, 0, 2'd1, 1, 24'h0, 8'h9B);

    // expand-up writable data
    ld ("R10 ld data",      1, 2'd2, 16'h0010, mkdesc(24'h123400, 16'h0FFF, 8'h92), 0, 8'd0);
    acc("R5_R6_R10 last byte", 1, 2'd2, 16'h0FFF, 0, 2'd0, 0, 24'h1243FF, 8'h93);
    acc("R6 word crosses",  1, 2'd2, 16'h0FFF, 1, 2'd0, 1, 24'h0, 8'h93);
    acc("R6 word fits",     1, 2'd2, 16'h0FFE, 1, 2'd0, 0, 24'h1243FE, 8'h93);
    acc("R6 byte past",     1, 2'd2, 16'h1000, 0, 2'd0, 1, 24'h0, 8'h93);
    acc("R8 data write ok", 1, 2'd2, 16'h0800, 1, 2'd1, 0, 24'h123C00, 8'h93);
    acc("R8 fetch data",    1, 2'd2, 16'h0010, 0, 2'd2, 1, 24'h0, 8'h93);

    // expand-down read-only data
    ld ("R7 ld expdn",      1, 2'd3, 16'h0018, mkdesc(24'h010000, 16'h7FFF, 8'h94), 0, 8'd0);
    acc("R7 at limit",      1, 2'd3, 16'h7FFF, 0, 2'd0, 1, 24'h0, 8'h95);
    acc("R7 above limit",   1, 2'd3, 16'h8000, 0, 2'd0, 0, 24'h018000, 8'h95);
    acc("R7 word top",      1, 2'd3, 16'hFFFF, 1, 2'd0, 1, 24'h0, 8'h95);
    acc("R7 byte top",      1, 2'd3, 16'hFFFF, 0, 2'd0, 0, 24'h01FFFF, 8'h95);
    acc("R8 ro write",      1, 2'd3, 16'h9000, 0, 2'd1, 1, 24'h0, 8'h95);

    // execute-only code
    ld ("R10 ld xonly",     1, 2'd0, 16'h0008, mkdesc(24'h200000, 16'h00FF, 8'h98), 0, 8'd0);
    acc("R8 xonly fetch",   1, 2'd0, 16'h0010, 0, 2'd2, 0, 24'h200010, 8'h99);
    acc("R8 xonly read",    1, 2'd0, 16'h0010, 0, 2'd0, 1, 24'h0, 8'h99);
    acc("R6 code past lim", 1, 2'd0, 16'h0100, 0, 2'd2, 1, 24'h0, 8'h99);

    // readable code in the stack entry
    ld ("R10 ld rcode",     1, 2'd1, 16'h0020, mkdesc(24'h300000, 16'hFFFF, 8'h9A), 0, 8'd0);
    acc("R8 rcode read",    1, 2'd1, 16'hFFFE, 1, 2'd0, 0, 24'h30FFFE, 8'h9B);
    acc("R8 rcode write",   1, 2'd1, 16'h0000, 0, 2'd1, 1, 24'h0, 8'h9B);

    // rejected loads
    ld ("R9 not present",   1, 2'd2, 16'h0030, mkdesc(24'h000000, 16'hFFFF, 8'h12), 1, 8'd11);
    acc("R9 data kept",     1, 2'd2, 16'h0010, 0, 2'd0, 0, 24'h123410, 8'h93);
    ld ("R9 system type",   1, 2'd3, 16'h0038, mkdesc(24'h000000, 16'hFFFF, 8'h82), 1, 8'd13);
    ld ("R9 sys and np",    1, 2'd3, 16'h0038, mkdesc(24'h000000, 16'hFFFF, 8'h02), 1, 8'd13);
    acc("R9 extra kept",    1, 2'd3, 16'h8000, 0, 2'd0, 0, 24'h018000, 8'h95);

    // R5: 24-bit wrap
    ld ("R5 ld high base",  1, 2'd1, 16'h0040, mkdesc(24'hFFFF00, 16'hFFFF, 8'h93), 0, 8'd0);
    acc("R5 wrap24",        1, 2'd1, 16'h0200, 0, 2'd0, 0, 24'h000100, 8'h93);

    // R12: idle request lines with faulting-looking stimulus
    begin
      exp_t e;
      @(negedge clk);
      prot_mode = 1'b1; ld_valid = 1'b0; acc_valid = 1'b0;
      ld_desc = mkdesc(24'h0, 16'h0, 8'h02);
      acc_seg = 2'd3; acc_off = 16'hFFFF; acc_word = 1'b1; acc_kind = 2'd1;
      e.tag = "R12 idle acc"; e.is_ld = 1'b0; e.fault = 1'b0; e.exc = 8'd0;
      e.chk_addr = 1'b0; e.addr = '0; e.chk_r = 1'b0; e.rights = '0;
      sb_q.push_back(e);
      e.tag = "R12 idle ld"; e.is_ld = 1'b1;
      sb_q.push_back(e);
    end
    repeat (4) @(negedge clk);

    done = 1'b1;
    if (sb_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule